// File: doc/BRIEF.md
# E1 Remote Alarm Indication Filter

This block watches the remote alarm flag carried in time slot 0 of the frames on an E1 receive path. The upstream framer tells it, one strobe per received time slot 0, whether that frame carries the frame alignment word and what value sits in the alarm position, bit 3. Only frames without the alignment word are examined. A run of three consecutive examined frames with the flag set raises the real-time alarm output. A run of three with the flag clear drops it again.

A host-facing sticky bit records every rising edge of the alarm output. It holds until the host pulses a clear strobe. While the framer reports that it is hunting for alignment, the block discards any partial run and keeps the alarm output where it is. An internal two-stage synchronizer releases the asynchronous reset on a clock edge.

Top module: `rai_filter`

## Requirements
- R1: A strobe (`ts0_vld`=1) with `ts0_is_fas`=1 marks an alignment frame. Such a frame neither advances nor restarts the run count, whatever its bit 3 value.
- R2: `rai_alarm` rises on the clock edge that samples the third consecutive qualifying frame (`ts0_vld`=1, `ts0_is_fas`=0, `resync`=0) with `ts0_bit3`=1.
- R3: `rai_alarm` falls on the clock edge that samples the third consecutive qualifying frame with `ts0_bit3`=0.
- R4: `rai_sticky` goes high one clock after every rising edge of `rai_alarm`.
- R5: A one-cycle pulse on `host_clr` clears `rai_sticky` on the next edge. The pulse does not set the bit again while the alarm stays high.
- R6: A qualifying frame whose bit 3 differs from the current run starts a new run of length one.
- R7: `resync`=1 empties the run count and keeps `rai_alarm` unchanged. A strobe presented in the same cycle is discarded.
- R8: After reset, `rai_alarm` and `rai_sticky` are both low.
- R9: When a rising edge of `rai_alarm` and a `host_clr` pulse act on `rai_sticky` in the same cycle, the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts0_vld | input | 1 | One-cycle strobe: a time slot 0 has been received |
| ts0_is_fas | input | 1 | The strobed frame carries the alignment word |
| ts0_bit3 | input | 1 | Value of bit 3 of the strobed time slot 0 |
| resync | input | 1 | The framer is searching for alignment |
| host_clr | input | 1 | One-cycle pulse that clears the sticky bit |
| rai_alarm | output | 1 | Real-time filtered remote alarm |
| rai_sticky | output | 1 | Sticky record of alarm onsets |

## Verification
The alarm output is registered once behind the input strobe, so it settles on the first edge after a qualifying frame is sampled. The sticky bit settles one edge later. Each stimulus holds its inputs for one cycle. The next cycle carries the optional clear pulse. The expected item is compared at the falling edge after the second rising edge, when both results are due and stable. This ordering also lines a clear pulse up with the cycle in which an alarm onset reaches the sticky register, which is how the set-over-clear case is exercised.

// File: rtl/rai_pkg.sv
package rai_pkg;
  // Decision taken on one cycle of framer input.
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_FLUSH = 2'd1,
    EV_TAKE  = 2'd2
  } rai_ev_e;

  typedef struct packed {
    rai_ev_e ev;
    logic    bit3;
  } rai_evt_t;
endpackage

// File: rtl/rai_qualify.sv
module rai_qualify
  import rai_pkg::*;
(
  input  logic     vld,
  input  logic     is_fas,
  input  logic     bit3,
  input  logic     resync,
  output rai_evt_t evt
);
  always_comb begin
    evt.bit3 = bit3;
    if (resync)
      evt.ev = EV_FLUSH;
    else if (vld && !is_fas)
      evt.ev = EV_TAKE;
    else
      evt.ev = EV_IDLE;
  end
endmodule

// File: rtl/rai_persist.sv
module rai_persist
  import rai_pkg::*;
#(
  parameter int RUN_LEN = 3,
  localparam int CW = $clog2(RUN_LEN + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rai_evt_t evt,
  output logic     alarm
);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          val_q, val_d;
  logic          alm_q, alm_d;
  logic          en;

  always_comb begin
    cnt_d = cnt_q;
    val_d = val_q;
    alm_d = alm_q;
    en    = 1'b0;
    case (evt.ev)
      EV_FLUSH: begin
        en    = 1'b1;
        cnt_d = '0;
      end
      EV_TAKE: begin
        en = 1'b1;
        if ((cnt_q != '0) && (evt.bit3 == val_q)) begin
          if (cnt_q != RUN_MAX) cnt_d = cnt_q + 1'b1;
        end else begin
          val_d = evt.bit3;
          cnt_d = CW'(1);
        end
        if (cnt_d == RUN_MAX) alm_d = val_d;
      end
      default: en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= 1'b0;
      alm_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      val_q <= val_d;
      alm_q <= alm_d;
    end
  end

  assign alarm = alm_q;
endmodule

// File: rtl/rai_sticky.sv
module rai_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm,
  input  logic clr,
  output logic sticky
);
  logic prev_q, stk_q, stk_d, rise;

  always_comb begin
    rise  = alarm && !prev_q;
    stk_d = stk_q;
    if (clr)  stk_d = 1'b0;
    if (rise) stk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stk_q  <= 1'b0;
    end else begin
      prev_q <= alarm;
      stk_q  <= stk_d;
    end
  end

  assign sticky = stk_q;
endmodule

// File: rtl/rai_filter.sv
module rai_filter
  import rai_pkg::*;
#(
  parameter int RUN_LEN  = 3,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ts0_vld,
  input  logic ts0_is_fas,
  input  logic ts0_bit3,
  input  logic resync,
  input  logic host_clr,
  output logic rai_alarm,
  output logic rai_sticky
);
  logic [SYNC_STG-1:0] rs_q;
  logic                rst_sync_n;
  rai_evt_t            evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[SYNC_STG-1];

  rai_qualify u_qual (
    .vld    (ts0_vld),
    .is_fas (ts0_is_fas),
    .bit3   (ts0_bit3),
    .resync (resync),
    .evt    (evt)
  );

  rai_persist #(.RUN_LEN(RUN_LEN)) u_pers (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt   (evt),
    .alarm (rai_alarm)
  );

  rai_sticky u_stk (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .alarm  (rai_alarm),
    .clr    (host_clr),
    .sticky (rai_sticky)
  );
endmodule

// File: rtl/rai_filter_chk.sv
module rai_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic ts0_vld,
  input logic ts0_is_fas,
  input logic ts0_bit3,
  input logic resync,
  input logic host_clr,
  input logic rai_alarm,
  input logic rai_sticky
);
  assert_alarm_needs_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ts0_vld && !ts0_is_fas && !resync) |=> $stable(rai_alarm));

  assert_rise_on_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rai_alarm) |-> $past(ts0_bit3));

  assert_fall_on_clear_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rai_alarm) |-> !$past(ts0_bit3));

  assert_sticky_follows_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rai_alarm) |=> rai_sticky);

  assert_sticky_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rai_sticky) |-> $past(host_clr));

  assert_resync_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> $stable(rai_alarm));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rai_alarm) && host_clr) |=> rai_sticky);
endmodule

bind rai_filter rai_filter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ts0_vld    (ts0_vld),
  .ts0_is_fas (ts0_is_fas),
  .ts0_bit3   (ts0_bit3),
  .resync     (resync),
  .host_clr   (host_clr),
  .rai_alarm  (rai_alarm),
  .rai_sticky (rai_sticky)
);

// File: tb/sim_rai_filter.sv
module sim_rai_filter;
  logic clk = 1'b0;
  logic rst_n;
  logic ts0_vld, ts0_is_fas, ts0_bit3, resync, host_clr;
  logic rai_alarm, rai_sticky;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  alarm;
    logic  sticky;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  // Requirement-level model state
  logic m_alarm, m_sticky, m_val;
  int   m_run;

  always #4 clk = ~clk;

  rai_filter u0 (
    .clk(clk), .rst_n(rst_n), .ts0_vld(ts0_vld), .ts0_is_fas(ts0_is_fas),
    .ts0_bit3(ts0_bit3), .resync(resync), .host_clr(host_clr),
    .rai_alarm(rai_alarm), .rai_sticky(rai_sticky)
  );

  // Monitor: pop and compare when an item falls due
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rai_alarm !== e.alarm || rai_sticky !== e.sticky) begin
          fails++;
          $display("FAIL %s: alarm=%b sticky=%b expected alarm=%b sticky=%b",
                   e.tag, rai_alarm, rai_sticky, e.alarm, e.sticky);
        end
      end
    end
  end

  // Driver: one input cycle, then a cycle carrying the optional clear
  task automatic step(input logic vld, input logic fas, input logic b3,
                      input logic rs, input logic clr, input string tag);
    logic old_alarm;
    exp_t e;
    @(negedge clk);
    ts0_vld = vld; ts0_is_fas = fas; ts0_bit3 = b3; resync = rs;
    old_alarm = m_alarm;
    if (rs) m_run = 0;
    else if (vld && !fas) begin
      if (m_run > 0 && b3 == m_val) begin
        if (m_run < 3) m_run++;
      end else begin
        m_val = b3;
        m_run = 1;
      end
      if (m_run == 3) m_alarm = m_val;
    end
    @(negedge clk);
    ts0_vld = 1'b0; ts0_is_fas = 1'b0; ts0_bit3 = 1'b0; resync = 1'b0;
    host_clr = clr;
    if (m_alarm && !old_alarm) m_sticky = 1'b1;
    else if (clr) m_sticky = 1'b0;
    @(negedge clk);
    host_clr = 1'b0;
    e.alarm = m_alarm; e.sticky = m_sticky; e.tag = tag;
    exp_q.push_back(e);
    ->chk_ev;
  endtask

  task automatic nfas(input logic b3, input string tag);
    step(1'b1, 1'b0, b3, 1'b0, 1'b0, tag);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ts0_vld = 0; ts0_is_fas = 0; ts0_bit3 = 0; resync = 0; host_clr = 0;
    m_alarm = 0; m_sticky = 0; m_val = 0; m_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset");
    // R2 / R4: three set frames raise the alarm, sticky follows
    nfas(1'b1, "R2 first set frame");
    nfas(1'b1, "R2 second set frame");
    nfas(1'b1, "R2 third set frame, R4 sticky");
    // R1: alignment frames with bit 3 clear are ignored
    repeat (4) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 alignment frame ignored");
    // R5: clear the sticky bit while the alarm stays high
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 host clear");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 stays clear");
    // R6: an interrupting set frame restarts the clear run
    nfas(1'b0, "R6 clear run 1");
    nfas(1'b0, "R6 clear run 2");
    nfas(1'b1, "R6 run broken");
    nfas(1'b0, "R6 new clear run 1");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 alignment frame between");
    nfas(1'b0, "R6 new clear run 2");
    nfas(1'b0, "R3 third clear frame drops alarm");
    // R7: resync empties the run
    nfas(1'b1, "R7 set 1");
    nfas(1'b1, "R7 set 2");
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 strobe during resync dropped");
    nfas(1'b1, "R7 set after resync is run 1");
    nfas(1'b1, "R7 run 2");
    nfas(1'b1, "R7 run 3 raises alarm");
    // R7: resync holds a high alarm
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7 resync holds alarm");
    nfas(1'b0, "R7 clear 1");
    nfas(1'b0, "R7 clear 2");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7 resync mid run");
    nfas(1'b0, "R7 clear restarted");
    nfas(1'b0, "R7 clear 2 again");
    nfas(1'b0, "R3 clear 3 drops alarm");
    // R9: set beats clear in the same cycle
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 clear before R9");
    nfas(1'b1, "R9 set 1");
    nfas(1'b1, "R9 set 2");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 rise with clear keeps sticky");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule